// File: doc/BRIEF.md
# Multichannel Latching Scaler Array

A bank of independent event counters, one per input channel. Each channel input passes through a two-flop synchroniser and a rising-edge detector, and every detected rising edge advances that channel's counter by one. The counters are `CW` bits wide (32 by default), and there are `NCH` of them (8 by default, at most 128). A single-cycle trigger pulse copies every counter into its own latch at one clock edge. Counting goes on across that edge without losing a cycle, so a read of the latches gives one consistent snapshot of all channels.

A shared gate input is synchronised in the same way as the channel inputs. A two-bit mode selects what the gate does:
- It blocks counting on all channels.
- It holds every counter at zero.
- It acts as a common test stimulus whose rising edges every channel counts.
- In the fourth code it does nothing.

The counters can be cleared by a software clear pulse. They can also be cleared automatically with each trigger, so that the latches hold the count between two successive triggers. A registered live-read port returns the current value of any counter, selected by index.

Top module: `scaler_bank`

## Requirements
- R1: A rising edge on `ch_in[i]` makes counter i one greater. The new value shows on the live-read path from the third rising clock edge after the input change (two synchroniser flops, then the counter). A level that is held high adds only one count.
- R2: At a clock edge where `trig` is 1, each latch i takes the value counter i had before that edge. At all other edges the latches keep their values. Counters still take the increment of that edge unless a clear applies.
- R3: With `gate_mode` = 2'b00 and the synchronised gate high, no counter changes except through a clear.
- R4: With `gate_mode` = 2'b01 and the synchronised gate high, every counter is held at zero.
- R5: With `gate_mode` = 2'b10, each synchronised rising edge of `gate_in` counts once on every channel. A channel edge in the same cycle still gives a single increment.
- R6: With `gate_mode` = 2'b11, `gate_in` has no effect on counting.
- R7: When `auto_clr_en` is 1, a trigger clears every counter at the same edge where the latches load.
- R8: A `sw_clr` pulse sets every counter to zero at that edge. This takes priority over an increment and over an auto-clear.
- R9: `rd_data` shows the value counter `rd_idx` held just before the previous clock edge, with one cycle of latency. An index of `NCH` or above reads as zero.
- R10: If a channel edge falls on the edge of an auto-clearing trigger, the latch takes the old count and the counter restarts at 1.
- R11: A counter wraps from all ones to zero, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_in | input | NCH | Channel inputs, counted on rising edges |
| gate_in | input | 1 | Shared gate input |
| gate_mode | input | 2 | Gate role: 00 inhibit, 01 zero-hold, 10 test stimulus, 11 none |
| auto_clr_en | input | 1 | Clear counters with each trigger |
| trig | input | 1 | Latch all counters (single-cycle pulse) |
| sw_clr | input | 1 | Clear all counters (single-cycle pulse) |
| rd_idx | input | IW | Live-read channel index |
| rd_data | output | CW | Registered live value of the selected counter |
| latch_flat | output | NCH*CW | All latches; channel i at bits [i*CW +: CW] |

## Verification
Two events can land on one clock edge: a channel edge reaching its counter, and an auto-clearing trigger. The bench times a channel input rise so that its synchronised edge lands exactly on the trigger edge. It then expects the latch to hold the earlier count and a live read to return 1. Random phases also let software clears, zero-hold gating and triggers coincide with edges. Each of these is judged against a cycle-level reference model kept in the bench.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
   typedef enum logic [1:0] {
      GM_INHIBIT = 2'b00,
      GM_ZERO    = 2'b01,
      GM_TEST    = 2'b10,
      GM_SPARE   = 2'b11
   } gate_mode_t;
endpackage

// File: rtl/scaler_sync.sv
module scaler_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] lvl,
   output logic [W-1:0] dly
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [2:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[1:0], d[i]};
      end
      assign lvl[i] = sh[1];
      assign dly[i] = sh[2];
   end
endmodule

// File: rtl/scaler_gate_dec.sv
module scaler_gate_dec
   import scaler_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       lvl,
   input  logic       rise,
   output logic       inhibit,
   output logic       hold_zero,
   output logic       test_pulse
);
   gate_mode_t m;
   assign m = gate_mode_t'(mode);

   always_comb begin
      inhibit    = 1'b0;
      hold_zero  = 1'b0;
      test_pulse = 1'b0;
      case (m)
         GM_INHIBIT: inhibit    = lvl;
         GM_ZERO:    hold_zero  = lvl;
         GM_TEST:    test_pulse = rise;
         default:    ;
      endcase
   end
endmodule

// File: rtl/scaler_cell.sv
module scaler_cell #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          clr_now,
   input  logic          auto_clr,
   input  logic          trig,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] lat
);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lat <= '0;
      end else begin
         if (trig) lat <= cnt;
         if (clr_now)
            cnt <= '0;
         else if (trig && auto_clr)
            cnt <= inc ? ONE : '0;
         else if (inc)
            cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank #(
   parameter int NCH = 8,
   parameter int CW  = 32,
   localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    ch_in,
   input  logic              gate_in,
   input  logic [1:0]        gate_mode,
   input  logic              auto_clr_en,
   input  logic              trig,
   input  logic              sw_clr,
   input  logic [IW-1:0]     rd_idx,
   output logic [CW-1:0]     rd_data,
   output logic [NCH*CW-1:0] latch_flat
);
   if (NCH < 1 || NCH > 128) begin : g_bad_nch
      $error("scaler_bank: NCH must be 1..128");
   end
   if (CW < 2) begin : g_bad_cw
      $error("scaler_bank: CW must be at least 2");
   end

   logic [NCH:0]      s_lvl, s_dly;
   logic [NCH-1:0]    ch_rise;
   logic              inhibit, hold_zero, test_pulse;
   logic [NCH*CW-1:0] cnt_flat;
   logic [CW-1:0]     cnt_arr [NCH];

   scaler_sync #(.W(NCH + 1)) sync_i (
      .clk(clk), .rst_n(rst_n), .d({gate_in, ch_in}),
      .lvl(s_lvl), .dly(s_dly)
   );

   assign ch_rise = s_lvl[NCH-1:0] & ~s_dly[NCH-1:0];

   scaler_gate_dec gate_i (
      .mode(gate_mode), .lvl(s_lvl[NCH]),
      .rise(s_lvl[NCH] & ~s_dly[NCH]),
      .inhibit(inhibit), .hold_zero(hold_zero), .test_pulse(test_pulse)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      scaler_cell #(.CW(CW)) cell_i (
         .clk(clk), .rst_n(rst_n),
         .inc((ch_rise[i] | test_pulse) & ~inhibit),
         .clr_now(sw_clr | hold_zero),
         .auto_clr(auto_clr_en), .trig(trig),
         .cnt(cnt_arr[i]), .lat(latch_flat[i*CW +: CW])
      );
      assign cnt_flat[i*CW +: CW] = cnt_arr[i];
   end

   if ((1 << IW) == NCH) begin : g_rd_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= cnt_arr[rd_idx];
      end
   end else begin : g_rd_part
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     rd_data <= '0;
         else if (int'(rd_idx) < NCH)    rd_data <= cnt_arr[rd_idx];
         else                            rd_data <= '0;
      end
   end
endmodule

// File: rtl/scaler_bank_chk.sv
module scaler_bank_chk #(
   parameter int NCH = 8,
   parameter int CW  = 32,
   parameter int IW  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig,
   input logic              sw_clr,
   input logic              auto_clr_en,
   input logic              inhibit,
   input logic              hold_zero,
   input logic [IW-1:0]     rd_idx,
   input logic [CW-1:0]     rd_data,
   input logic [NCH*CW-1:0] cnt_flat,
   input logic [NCH*CW-1:0] latch_flat
);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
   logic [CW-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NCH; i++)
         if (int'(rd_idx) == i) sel = cnt_flat[i*CW +: CW];
   end

   assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> latch_flat == $past(cnt_flat));
   assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> $stable(latch_flat));
   assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit && !sw_clr && !hold_zero && !(trig && auto_clr_en)) |=> $stable(cnt_flat));
   assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_zero |=> cnt_flat == '0);
   assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> cnt_flat == '0);
   assert_live_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rd_data == $past(sel));

   for (genvar i = 0; i < NCH; i++) begin : g_step
      assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (cnt_flat[i*CW +: CW] == $past(cnt_flat[i*CW +: CW])) ||
                  (cnt_flat[i*CW +: CW] == $past(cnt_flat[i*CW +: CW]) + ONE) ||
                  (cnt_flat[i*CW +: CW] == '0) || (cnt_flat[i*CW +: CW] == ONE));
   end
endmodule

bind scaler_bank scaler_bank_chk #(.NCH(NCH), .CW(CW), .IW(IW)) chk_i (
   .clk(clk), .rst_n(rst_n), .trig(trig), .sw_clr(sw_clr),
   .auto_clr_en(auto_clr_en), .inhibit(inhibit), .hold_zero(hold_zero),
   .rd_idx(rd_idx), .rd_data(rd_data), .cnt_flat(cnt_flat),
   .latch_flat(latch_flat)
);

// File: tb/scaler_bank_tb.sv
module scaler_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;
   localparam int CW  = 8;
   localparam int IW  = 3;

   logic              clk = 0;
   logic              rst_n = 0;
   logic [NCH-1:0]    ch_in = '0;
   logic              gate_in = 0;
   logic [1:0]        gate_mode = 2'b11;
   logic              auto_clr_en = 0;
   logic              trig = 0;
   logic              sw_clr = 0;
   logic [IW-1:0]     rd_idx = '0;
   logic [CW-1:0]     rd_data;
   logic [NCH*CW-1:0] latch_flat;

   int checks = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scaler_bank #(.NCH(NCH), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .gate_in(gate_in),
      .gate_mode(gate_mode), .auto_clr_en(auto_clr_en), .trig(trig),
      .sw_clr(sw_clr), .rd_idx(rd_idx), .rd_data(rd_data),
      .latch_flat(latch_flat)
   );

   // reference model, per clock edge
   bit [2:0]      msh [NCH];
   bit [2:0]      gsh;
   logic [CW-1:0] mcnt [NCH];
   logic [CW-1:0] mlat [NCH];
   logic [CW-1:0] mrd;

   function automatic logic [CW-1:0] next_count(logic [CW-1:0] c, bit inc,
                                                 bit clr, bit tr, bit ac);
      if (clr)          return '0;
      if (tr && ac)     return inc ? CW'(1) : '0;
      return inc ? c + CW'(1) : c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            msh[i] = '0; mcnt[i] = '0; mlat[i] = '0;
         end
         gsh = '0; mrd = '0;
      end else begin
         bit inh, hz, tp, e;
         inh = (gate_mode == 2'b00) && gsh[1];
         hz  = (gate_mode == 2'b01) && gsh[1];
         tp  = (gate_mode == 2'b10) && gsh[1] && !gsh[2];
         mrd = (int'(rd_idx) < NCH) ? mcnt[rd_idx] : '0;
         for (int i = 0; i < NCH; i++) begin
            e = ((msh[i][1] && !msh[i][2]) || tp) && !inh;
            if (trig) mlat[i] = mcnt[i];
            mcnt[i] = next_count(mcnt[i], e, sw_clr || hz, trig, auto_clr_en);
            msh[i] = {msh[i][1:0], ch_in[i]};
         end
         gsh = {gsh[1:0], gate_in};
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_model(string tag);
      for (int i = 0; i < NCH; i++)
         chk(latch_flat[i*CW +: CW] == mlat[i], tag,
             int'(latch_flat[i*CW +: CW]), int'(mlat[i]));
      chk(rd_data == mrd, tag, int'(rd_data), int'(mrd));
   endtask

   task automatic read_live(int idx, output logic [CW-1:0] v);
      rd_idx = IW'(idx);
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic pulse_ch(int ch);
      @(negedge clk) ch_in[ch] = 1;
      repeat (2) @(negedge clk);
      ch_in[ch] = 0;
      @(negedge clk);
   endtask

   task automatic pulse_gate();
      @(negedge clk) gate_in = 1;
      repeat (2) @(negedge clk);
      gate_in = 0;
      @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk) sw_clr = 1;
      @(negedge clk) sw_clr = 0;
   endtask

   task automatic do_trig();
      @(negedge clk) trig = 1;
      @(negedge clk) trig = 0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic [CW-1:0] v;
      void'($urandom(32'h5ca1e));
      repeat (3) @(negedge clk);
      // reset state
      chk(latch_flat == '0, "R2 reset latches", int'(latch_flat[CW-1:0]), 0);
      chk(rd_data == '0, "R9 reset read", int'(rd_data), 0);
      rst_n = 1;
      settle();

      // R1: counting, held level counts once
      for (int k = 0; k < 3; k++) pulse_ch(2);
      @(negedge clk) ch_in[2] = 1;
      repeat (10) @(negedge clk);
      ch_in[2] = 0;
      settle();
      read_live(2, v);
      chk(v == 4, "R1 edge count", int'(v), 4);

      // R1 latency: visible on third edge
      @(negedge clk) ch_in[4] = 1;
      rd_idx = 3'd4;
      @(negedge clk);
      @(negedge clk);
      chk(rd_data == 0, "R1 not before third edge", int'(rd_data), 0);
      @(negedge clk);
      chk(rd_data == 0, "R1 read lags one", int'(rd_data), 0);
      @(negedge clk);
      chk(rd_data == 1, "R1 visible", int'(rd_data), 1);
      ch_in[4] = 0;
      settle();

      // R2: trigger snapshot, counting continues
      do_trig();
      chk(latch_flat[2*CW +: CW] == 4, "R2 latch ch2",
          int'(latch_flat[2*CW +: CW]), 4);
      pulse_ch(2);
      settle();
      chk(latch_flat[2*CW +: CW] == 4, "R2 latch holds",
          int'(latch_flat[2*CW +: CW]), 4);
      read_live(2, v);
      chk(v == 5, "R2 counting continues", int'(v), 5);

      // R9 out of range
      read_live(7, v);
      chk(v == 0, "R9 out of range", int'(v), 0);

      // R8 software clear
      do_clear();
      read_live(2, v);
      chk(v == 0, "R8 sw clear", int'(v), 0);

      // R6 spare mode: gate does nothing
      gate_mode = 2'b11;
      for (int k = 0; k < 3; k++) begin pulse_gate(); pulse_ch(1); end
      @(negedge clk) gate_in = 1;
      settle();
      pulse_ch(1);
      gate_in = 0;
      settle();
      read_live(1, v);
      chk(v == 4, "R6 spare mode", int'(v), 4);
      read_live(0, v);
      chk(v == 0, "R6 no gate counts", int'(v), 0);

      // R3 inhibit
      gate_mode = 2'b00;
      @(negedge clk) gate_in = 1;
      settle();
      for (int k = 0; k < 3; k++) pulse_ch(1);
      read_live(1, v);
      chk(v == 4, "R3 inhibit", int'(v), 4);
      gate_in = 0;
      settle();
      pulse_ch(1);
      settle();
      read_live(1, v);
      chk(v == 5, "R3 inhibit released", int'(v), 5);

      // R4 zero hold
      gate_mode = 2'b01;
      @(negedge clk) gate_in = 1;
      settle();
      pulse_ch(1);
      read_live(1, v);
      chk(v == 0, "R4 zero hold", int'(v), 0);
      gate_in = 0;
      settle();

      // R5 test stimulus, coincident with channel edge counts once
      gate_mode = 2'b10;
      pulse_gate();
      @(negedge clk) begin gate_in = 1; ch_in[3] = 1; end
      repeat (2) @(negedge clk);
      gate_in = 0; ch_in[3] = 0;
      settle();
      read_live(0, v);
      chk(v == 2, "R5 test ch0", int'(v), 2);
      read_live(3, v);
      chk(v == 2, "R5 test coincident", int'(v), 2);

      // R7 + R10: channel edge on an auto-clear trigger edge
      gate_mode = 2'b11;
      auto_clr_en = 1;
      do_clear();
      for (int k = 0; k < 3; k++) pulse_ch(0);
      settle();
      @(negedge clk) ch_in[0] = 1;
      @(negedge clk);
      @(negedge clk) trig = 1;
      @(negedge clk) begin trig = 0; ch_in[0] = 0; end
      chk(latch_flat[0 +: CW] == 3, "R10 latch old count",
          int'(latch_flat[0 +: CW]), 3);
      read_live(0, v);
      chk(v == 1, "R10 restart at one", int'(v), 1);
      read_live(1, v);
      chk(v == 0, "R7 auto clear", int'(v), 0);
      auto_clr_en = 0;

      // R11 wrap
      gate_mode = 2'b10;
      do_clear();
      for (int k = 0; k < 256; k++) pulse_gate();
      settle();
      read_live(5, v);
      chk(v == 0, "R11 wrap to zero", int'(v), 0);
      pulse_gate();
      settle();
      read_live(5, v);
      chk(v == 1, "R11 after wrap", int'(v), 1);

      // random phases against the model
      for (int ph = 0; ph < 8; ph++) begin
         gate_mode   = 2'(ph);
         auto_clr_en = ph[2];
         for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            ch_in   = ch_in ^ NCH'($urandom & $urandom);
            gate_in = (($urandom % 8) == 0) ? ~gate_in : gate_in;
            trig    = (($urandom % 16) == 0);
            sw_clr  = (($urandom % 97) == 0);
            rd_idx  = IW'($urandom);
         end
         @(negedge clk) begin trig = 0; sw_clr = 0; end
         check_model($sformatf("R1 R2 R3 R4 R5 R7 R8 R9 random phase %0d", ph));
      end

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule